// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block governs the low-power state of a small microcontroller core. When the core retires its sleep instruction, the controller stops the oscillator driver and gates the core clock. It also clears the watchdog counter and updates two status bits: a power-down flag and a time-out flag. While the core sleeps, the controller watches three kinds of wake event: the external reset input, a watchdog time-out, and the enabled interrupt sources.

On a watchdog or interrupt wake, the controller turns the oscillator back on. In the crystal-type modes it then waits for 1024 raw oscillator edges before it releases the core clock. In RC mode it releases the clock at once. The core first executes the instruction that was prefetched during sleep. If global interrupts were enabled and an interrupt took part in the wake, the controller then signals a redirect to the interrupt vector. That redirect cycle is a dummy cycle for the core. An external reset always ends in a full device reset pulse.

Top module: `slpw_ctrl`

## Requirements
- R1: After `rst`, `pd_o`=1, `to_o`=1, `osc_en_o`=1, `core_clk_en_o`=1 and `clk_ready_o`=1, and every pulse output (`wdt_clr_o`, `dev_rst_o`, `exec_next_o`, `vector_o`) is 0.
- R2: A `sleep_i` strobe while running takes effect in the next cycle. From that cycle `pd_o`=0, `to_o`=1, `osc_en_o`=0, `core_clk_en_o`=0 and `clk_ready_o`=0. `wdt_clr_o` is high for exactly that one cycle.
- R3: While asleep, a wake happens if `wdt_to_i` and `wdt_en_i` are both high, or if any bit of `irq_flag_i & irq_en_i` is set. The bits are 0 = external pin, 1 = port change, 2 = EEPROM write done. `gie_i` plays no part in the wake. A flag without its enable, or a time-out with the watchdog disabled, leaves the oscillator and core clock off.
- R4: A wake in which the watchdog condition holds clears `to_o`, even if an interrupt wakes in the same cycle. That interrupt is still honoured for vectoring. An interrupt-only wake leaves `to_o`=1. `pd_o` stays 0 through the wake.
- R5: `osc_en_o` returns to 1 in the cycle after the wake edge.
- R6: In a crystal-type mode (`osc_mode_i` 01, 10 or 11), the controller counts `osc_tick_i` from the first edge after the wake edge. `core_clk_en_o` and `clk_ready_o` rise in the cycle after the edge that samples the 1024th counted tick, and not before.
- R7: In RC mode (`osc_mode_i`=00), `core_clk_en_o` and `clk_ready_o` rise in the same cycle as `osc_en_o`.
- R8: `exec_next_o` is a single-cycle pulse in the cycle the core clock returns. It marks the execution of the instruction prefetched before sleep.
- R9: If `gie_i` was 1 at the wake edge and an enabled interrupt took part in the wake, `vector_o` pulses for one cycle in the cycle after `exec_next_o`. Otherwise `vector_o` stays 0.
- R10: `ext_rst_i` produces a `dev_rst_o` pulse in the next cycle from any state. From that cycle on, `osc_en_o`, `core_clk_en_o` and `clk_ready_o` are 1, and `pd_o` and `to_o` are left unchanged.
- R11: `sleep_i` has no effect unless the core is running. Outside the running state it gives no `wdt_clr_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_i | input | 1 | External reset input, active high |
| sleep_i | input | 1 | Sleep instruction retire strobe |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_to_i | input | 1 | Watchdog time-out |
| osc_mode_i | input | 2 | Oscillator mode: 00 RC, 01 LP, 10 XT, 11 HS |
| osc_tick_i | input | 1 | One strobe per raw oscillator edge |
| gie_i | input | 1 | Global interrupt enable |
| irq_flag_i | input | 3 | Interrupt flags (pin, port change, EEPROM done) |
| irq_en_i | input | 3 | Matching interrupt enables |
| osc_en_o | output | 1 | Oscillator driver enable |
| core_clk_en_o | output | 1 | Core clock gate enable |
| clk_ready_o | output | 1 | Start-up wait complete |
| pd_o | output | 1 | Power-down status bit |
| to_o | output | 1 | Time-out status bit |
| wdt_clr_o | output | 1 | Watchdog counter clear pulse |
| dev_rst_o | output | 1 | Full device reset pulse |
| exec_next_o | output | 1 | Execute prefetched instruction pulse |
| vector_o | output | 1 | Dummy cycle, branch to interrupt vector pulse |

## Verification
A controller stuck in or skipping a state shows up right away at the ports. The core clock may return early or late against the bench's own tick count. The oscillator may come on for a source that is not enabled. A wrong latched vector decision shows up one cycle after `exec_next_o` as a missing or extra `vector_o`. A status register corrupted by the wake source shows up as a wrong `to_o` in the first cycle after the wake edge.

// File: rtl/slpw_pkg.sv
package slpw_pkg;
  typedef enum logic [1:0] {
    OSC_RC = 2'b00,
    OSC_LP = 2'b01,
    OSC_XT = 2'b10,
    OSC_HS = 2'b11
  } osc_mode_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_START = 2'd2,
    ST_VECT  = 2'd3
  } pm_state_t;
endpackage

// File: rtl/slpw_wake_detect.sv
module slpw_wake_detect #(
  parameter int N_IRQ = 3
) (
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             wdt_en,
  input  logic             wdt_to,
  output logic             irq_hit,
  output logic             wdt_hit,
  output logic             wake
);
  logic [N_IRQ-1:0] armed;

  // one gate per source, so a new source only widens the vector
  for (genvar g = 0; g < N_IRQ; g++) begin : g_src
    assign armed[g] = irq_flag[g] & irq_en[g];
  end

  assign irq_hit = |armed;
  assign wdt_hit = wdt_en & wdt_to;
  assign wake    = irq_hit | wdt_hit;
endmodule

// File: rtl/slpw_startup_cnt.sv
module slpw_startup_cnt #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick && cnt != LAST) cnt <= cnt + 1'b1;
  end

  // terminal tick: the edge that samples the LIMIT-th oscillator edge
  assign done = run && tick && (cnt == LAST);
endmodule

// File: rtl/slpw_ctrl.sv
module slpw_ctrl
  import slpw_pkg::*;
#(
  parameter int N_IRQ       = 3,
  parameter int STARTUP_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_rst_i,
  input  logic             sleep_i,
  input  logic             wdt_en_i,
  input  logic             wdt_to_i,
  input  logic [1:0]       osc_mode_i,
  input  logic             osc_tick_i,
  input  logic             gie_i,
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  output logic             osc_en_o,
  output logic             core_clk_en_o,
  output logic             clk_ready_o,
  output logic             pd_o,
  output logic             to_o,
  output logic             wdt_clr_o,
  output logic             dev_rst_o,
  output logic             exec_next_o,
  output logic             vector_o
);
  pm_state_t state;
  logic      vec_pend;
  logic      irq_hit, wdt_hit, wake;
  logic      cnt_done;
  logic      skip_start;
  logic      vec_now;

  slpw_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .irq_flag (irq_flag_i),
    .irq_en   (irq_en_i),
    .wdt_en   (wdt_en_i),
    .wdt_to   (wdt_to_i),
    .irq_hit  (irq_hit),
    .wdt_hit  (wdt_hit),
    .wake     (wake)
  );

  slpw_startup_cnt #(.LIMIT(STARTUP_CYC)) u_start (
    .clk  (clk),
    .rst  (rst),
    .run  (state == ST_START),
    .tick (osc_tick_i),
    .done (cnt_done)
  );

  assign skip_start = (osc_mode_t'(osc_mode_i) == OSC_RC);
  assign vec_now    = gie_i & irq_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_RUN;
      vec_pend      <= 1'b0;
      osc_en_o      <= 1'b1;
      core_clk_en_o <= 1'b1;
      clk_ready_o   <= 1'b1;
      pd_o          <= 1'b1;
      to_o          <= 1'b1;
      wdt_clr_o     <= 1'b0;
      dev_rst_o     <= 1'b0;
      exec_next_o   <= 1'b0;
      vector_o      <= 1'b0;
    end else begin
      wdt_clr_o   <= 1'b0;
      dev_rst_o   <= 1'b0;
      exec_next_o <= 1'b0;
      vector_o    <= 1'b0;
      if (ext_rst_i) begin
        state         <= ST_RUN;
        vec_pend      <= 1'b0;
        osc_en_o      <= 1'b1;
        core_clk_en_o <= 1'b1;
        clk_ready_o   <= 1'b1;
        dev_rst_o     <= 1'b1;
      end else begin
        unique case (state)
          ST_RUN: if (sleep_i) begin
            state         <= ST_SLEEP;
            pd_o          <= 1'b0;
            to_o          <= 1'b1;
            osc_en_o      <= 1'b0;
            core_clk_en_o <= 1'b0;
            clk_ready_o   <= 1'b0;
            wdt_clr_o     <= 1'b1;
          end
          ST_SLEEP: if (wake) begin
            osc_en_o <= 1'b1;
            vec_pend <= vec_now;
            if (wdt_hit) to_o <= 1'b0;
            if (skip_start) begin
              core_clk_en_o <= 1'b1;
              clk_ready_o   <= 1'b1;
              exec_next_o   <= 1'b1;
              state         <= vec_now ? ST_VECT : ST_RUN;
            end else begin
              state <= ST_START;
            end
          end
          ST_START: if (cnt_done) begin
            core_clk_en_o <= 1'b1;
            clk_ready_o   <= 1'b1;
            exec_next_o   <= 1'b1;
            state         <= vec_pend ? ST_VECT : ST_RUN;
          end
          ST_VECT: begin
            vector_o <= 1'b1;
            vec_pend <= 1'b0;
            state    <= ST_RUN;
          end
          default: state <= ST_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/slpw_ctrl_chk.sv
module slpw_ctrl_chk #(
  parameter int N_IRQ = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ext_rst_i,
  input logic             sleep_i,
  input logic             wdt_en_i,
  input logic             wdt_to_i,
  input logic [N_IRQ-1:0] irq_flag_i,
  input logic [N_IRQ-1:0] irq_en_i,
  input logic [1:0]       state,
  input logic             osc_en_o,
  input logic             core_clk_en_o,
  input logic             clk_ready_o,
  input logic             pd_o,
  input logic             to_o,
  input logic             wdt_clr_o,
  input logic             dev_rst_o,
  input logic             exec_next_o,
  input logic             vector_o
);
  assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0 && sleep_i && !ext_rst_i) |=> (!pd_o && to_o && !osc_en_o && wdt_clr_o));

  assert_clr_single_R2: assert property (@(posedge clk) disable iff (rst)
    wdt_clr_o |=> !wdt_clr_o);

  assert_no_spurious_wake_R3: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd1 && !ext_rst_i && !(wdt_en_i && wdt_to_i) && ((irq_flag_i & irq_en_i) == '0))
      |=> !osc_en_o);

  assert_to_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(to_o) |-> $past(wdt_to_i && wdt_en_i));

  assert_clk_needs_osc_R5: assert property (@(posedge clk) disable iff (rst)
    core_clk_en_o |-> osc_en_o);

  assert_exec_clocked_R8: assert property (@(posedge clk) disable iff (rst)
    exec_next_o |-> (core_clk_en_o && clk_ready_o));

  assert_vector_after_exec_R9: assert property (@(posedge clk) disable iff (rst)
    vector_o |-> $past(exec_next_o));

  assert_reset_runs_R10: assert property (@(posedge clk) disable iff (rst)
    dev_rst_o |-> (osc_en_o && core_clk_en_o));
endmodule

bind slpw_ctrl slpw_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ext_rst_i     (ext_rst_i),
  .sleep_i       (sleep_i),
  .wdt_en_i      (wdt_en_i),
  .wdt_to_i      (wdt_to_i),
  .irq_flag_i    (irq_flag_i),
  .irq_en_i      (irq_en_i),
  .state         (state),
  .osc_en_o      (osc_en_o),
  .core_clk_en_o (core_clk_en_o),
  .clk_ready_o   (clk_ready_o),
  .pd_o          (pd_o),
  .to_o          (to_o),
  .wdt_clr_o     (wdt_clr_o),
  .dev_rst_o     (dev_rst_o),
  .exec_next_o   (exec_next_o),
  .vector_o      (vector_o)
);

// File: tb/slpw_ctrl_test.sv
module slpw_ctrl_test;
  logic       clk = 1'b0;
  logic       rst, ext_rst_i, sleep_i, wdt_en_i, wdt_to_i, osc_tick_i, gie_i;
  logic [1:0] osc_mode_i;
  logic [2:0] irq_flag_i, irq_en_i;
  logic osc_en_o, core_clk_en_o, clk_ready_o, pd_o, to_o;
  logic wdt_clr_o, dev_rst_o, exec_next_o, vector_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  slpw_ctrl uut (
    .clk(clk), .rst(rst), .ext_rst_i(ext_rst_i), .sleep_i(sleep_i),
    .wdt_en_i(wdt_en_i), .wdt_to_i(wdt_to_i), .osc_mode_i(osc_mode_i),
    .osc_tick_i(osc_tick_i), .gie_i(gie_i), .irq_flag_i(irq_flag_i),
    .irq_en_i(irq_en_i), .osc_en_o(osc_en_o), .core_clk_en_o(core_clk_en_o),
    .clk_ready_o(clk_ready_o), .pd_o(pd_o), .to_o(to_o), .wdt_clr_o(wdt_clr_o),
    .dev_rst_o(dev_rst_o), .exec_next_o(exec_next_o), .vector_o(vector_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_to(input logic en, input logic tout);
    return !(en && tout);
  endfunction

  function automatic logic exp_vec(input logic g, input logic [2:0] f, input logic [2:0] e);
    return g && ((f & e) != 3'b000);
  endfunction

  task automatic do_reset();
    rst = 1'b1; ext_rst_i = 1'b0; sleep_i = 1'b0; wdt_en_i = 1'b0; wdt_to_i = 1'b0;
    osc_tick_i = 1'b0; gie_i = 1'b0; osc_mode_i = 2'b00; irq_flag_i = '0; irq_en_i = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic enter_sleep();
    sleep_i = 1'b1;
    @(negedge clk);
    sleep_i = 1'b0;
    check("R2", "pd", pd_o, 1'b0);
    check("R2", "to", to_o, 1'b1);
    check("R2", "osc_en", osc_en_o, 1'b0);
    check("R2", "clk_en", core_clk_en_o, 1'b0);
    check("R2", "ready", clk_ready_o, 1'b0);
    check("R2", "wdt_clr", wdt_clr_o, 1'b1);
    @(negedge clk);
    check("R2", "wdt_clr single", wdt_clr_o, 1'b0);
  endtask

  task automatic wake_run(input logic [1:0] mode, input logic g, input logic we,
                          input logic wt, input logic [2:0] f, input logic [2:0] e,
                          input bit rnd_ticks);
    logic v;
    int   driven;
    v = exp_vec(g, f, e);
    osc_mode_i = mode;
    gie_i = g; wdt_en_i = we; wdt_to_i = wt; irq_flag_i = f; irq_en_i = e;
    osc_tick_i = 1'b1;  // tick at the wake edge must not be counted
    @(negedge clk);
    wdt_to_i = 1'b0; irq_flag_i = '0; osc_tick_i = 1'b0;
    check("R5", "osc_en after wake", osc_en_o, 1'b1);
    check("R4", "to after wake", to_o, exp_to(we, wt));
    check("R4", "pd after wake", pd_o, 1'b0);
    if (mode == 2'b00) begin
      check("R7", "clk_en rc", core_clk_en_o, 1'b1);
      check("R7", "ready rc", clk_ready_o, 1'b1);
    end else begin
      driven = 0;
      for (int i = 0; i < 6000; i++) begin
        if (core_clk_en_o || driven > 1024) break;
        osc_tick_i = rnd_ticks ? 1'($urandom_range(0, 1)) : 1'b1;
        driven += int'(osc_tick_i);
        @(negedge clk);
      end
      osc_tick_i = 1'b0;
      check("R6", "ticks at clock release", driven, 1024);
      check("R6", "ready", clk_ready_o, 1'b1);
    end
    check("R8", "exec_next", exec_next_o, 1'b1);
    check("R9", "no vector yet", vector_o, 1'b0);
    @(negedge clk);
    check("R8", "exec single", exec_next_o, 1'b0);
    check("R9", "vector", vector_o, v);
    @(negedge clk);
    check("R9", "vector single", vector_o, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4217));
    do_reset();
    // R1 reset state
    check("R1", "pd", pd_o, 1'b1);
    check("R1", "to", to_o, 1'b1);
    check("R1", "osc_en", osc_en_o, 1'b1);
    check("R1", "clk_en", core_clk_en_o, 1'b1);
    check("R1", "ready", clk_ready_o, 1'b1);
    check("R1", "pulses", {wdt_clr_o, dev_rst_o, exec_next_o, vector_o}, 4'b0000);

    // R3 non-waking stimuli, R11 sleep while asleep
    enter_sleep();
    irq_flag_i = 3'b111; irq_en_i = 3'b000; wdt_to_i = 1'b1; wdt_en_i = 1'b0; gie_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R3", "osc stays off", osc_en_o, 1'b0);
    check("R3", "clk stays off", core_clk_en_o, 1'b0);
    irq_flag_i = 3'b010; irq_en_i = 3'b101; wdt_to_i = 1'b0;
    @(negedge clk);
    check("R3", "unmatched enable", osc_en_o, 1'b0);
    sleep_i = 1'b1;
    @(negedge clk);
    sleep_i = 1'b0;
    check("R11", "no clear while asleep", wdt_clr_o, 1'b0);
    check("R11", "still off", osc_en_o, 1'b0);

    // R3/R9 interrupt wake with gie off, RC: no vector
    wake_run(2'b00, 1'b0, 1'b0, 1'b0, 3'b001, 3'b001, 1'b0);
    // R9 gie on, XT, port change
    enter_sleep();
    wake_run(2'b10, 1'b1, 1'b0, 1'b0, 3'b010, 3'b010, 1'b0);
    // R4 watchdog only wake, HS
    enter_sleep();
    wake_run(2'b11, 1'b1, 1'b1, 1'b1, 3'b000, 3'b111, 1'b0);
    // R4 watchdog and EEPROM done same cycle, LP: to cleared and vector taken
    enter_sleep();
    wake_run(2'b01, 1'b1, 1'b1, 1'b1, 3'b100, 3'b100, 1'b1);
    // R2 sleep entry resets to to 1
    enter_sleep();

    // R10 external reset during start-up
    osc_mode_i = 2'b10; irq_flag_i = 3'b001; irq_en_i = 3'b001; wdt_en_i = 1'b0;
    @(negedge clk);
    irq_flag_i = '0;
    repeat (5) @(negedge clk);
    check("R6", "still waiting", core_clk_en_o, 1'b0);
    ext_rst_i = 1'b1;
    @(negedge clk);
    ext_rst_i = 1'b0;
    check("R10", "dev_rst", dev_rst_o, 1'b1);
    check("R10", "osc_en", osc_en_o, 1'b1);
    check("R10", "clk_en", core_clk_en_o, 1'b1);
    check("R10", "pd kept", pd_o, 1'b0);
    check("R10", "to kept", to_o, 1'b1);
    @(negedge clk);
    check("R10", "dev_rst single", dev_rst_o, 1'b0);
    check("R10", "no exec", exec_next_o, 1'b0);

    // random wakes
    for (int n = 0; n < 16; n++) begin
      logic [1:0] m;
      logic g, we, wt;
      logic [2:0] f, e;
      m  = 2'($urandom_range(0, 3));
      g  = 1'($urandom_range(0, 1));
      we = 1'($urandom_range(0, 1));
      wt = 1'($urandom_range(0, 1));
      f  = 3'($urandom_range(0, 7));
      e  = 3'($urandom_range(0, 7));
      if (!(we && wt) && ((f & e) == 3'b000)) begin
        f[0] = 1'b1; e[0] = 1'b1;
      end
      enter_sleep();
      wake_run(m, g, we, wt, f, e, 1'b1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule